// File: doc/BRIEF.md
# Nested Priority Interrupt Vector Controller for a Two-Channel Serial Port

This block gathers the interrupt causes of a two-channel serial controller and presents them to the host as one active-low request line. Each channel has three sources: receive, transmit and external/status. The external/status source fires on a change of any of the channel's three modem lines (carrier detect, clear-to-send, sync). It also fires on a line break, an abort sequence or a transmit underrun, but only in the framing mode where that event is meaningful. Once the external/status source fires, it freezes until the host rearms it.

The block keeps a nested in-service record. The request line goes low only when the best pending cause strictly outranks the best cause already in service. A lower cause waits, still pending, until it becomes the highest outstanding one. When the host issues a dedicated acknowledge read, the block returns a vector: the host-programmed base with three bits replaced by a code for the winning channel and cause. The winning cause then moves from pending to in service. An end-of-interrupt strobe retires the highest cause in service, so held causes can be signalled again.

Top module: `serial_irq_ctrl`

## Requirements
- R1: After reset `int_n` is 1, `vector` is 0, and no cause is pending or in service.
- R2: Causes rank from highest to lowest as: channel 0 receive, channel 0 transmit, channel 0 external/status, channel 1 receive, channel 1 transmit, channel 1 external/status. An acknowledge serves the highest pending cause that is not in service.
- R3: The acknowledge vector equals the base with bits [3:1] replaced by {channel is 0, type[1:0]}. The type codes are transmit 00, external/status 01, receive 10, special receive 11. All other base bits pass through unchanged.
- R4: `int_n` is 0 exactly when some cause is pending and not in service, and that cause strictly outranks every cause in service (or nothing is in service).
- R5: A pending cause that ranks below the cause in service keeps `int_n` at 1 and is signalled once end-of-interrupt strobes have retired every cause above it.
- R6: An acknowledge taken while `int_n` is 0 moves the winning cause from pending to in service, and the new vector appears on the next cycle.
- R7: An `eoi` pulse retires only the highest-ranked cause in service.
- R8: While armed, any change on a channel's `dcd`, `cts` or `sync` line raises that channel's external/status cause.
- R9: An acknowledge while `int_n` is 1 changes neither `vector` nor any pending or in-service state.
- R10: `ch_mode` per channel uses 00 async, 01 byte-sync, 10 bit-sync and 11 reserved. A break pulse raises external/status only in async. An abort pulse raises it only in bit-sync. An underrun pulse raises it only in byte-sync or bit-sync.
- R11: After an external/status cause is raised, that channel ignores all further line changes and events until its `ext_reset` pulse. The pulse rearms detection against the current line levels.
- R12: A receive pulse that comes with `rx_special` reports type code 11. The flag clears when that receive cause is acknowledged, so a later plain receive pulse reports code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the vector base |
| base_din | input | 8 | New vector base |
| ack_rd | input | 1 | Acknowledge read strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| rx_ready | input | 2 | Receive cause pulse per channel |
| rx_special | input | 2 | Marks the receive pulse as a special receive condition |
| tx_empty | input | 2 | Transmit cause pulse per channel |
| ch_mode | input | 4 | Framing mode, 2 bits per channel, channel 0 in [1:0] |
| dcd | input | 2 | Carrier detect line per channel |
| cts | input | 2 | Clear-to-send line per channel |
| sync | input | 2 | Sync line per channel |
| break_det | input | 2 | Line break detected pulse per channel |
| abort_det | input | 2 | Abort sequence detected pulse per channel |
| tx_underrun | input | 2 | Transmit underrun/end-of-message pulse per channel |
| ext_reset | input | 2 | Rearm external/status detection per channel |
| int_n | output | 1 | Active-low interrupt request |
| vector | output | 8 | Vector returned by the last acknowledge |

## Verification
The bench builds the block with its default 8-bit vector. This gives two full channels, so every one of the eight codes in bits [3:1] can be produced and checked against two different base values. The default width leaves base bits on both sides of the code field, so it also shows that those bits pass through unchanged. With six sources, the nesting can be driven through preemption, holding and release in a few dozen cycles, and every mode-qualified external/status event can be tried against every framing mode.

// File: rtl/sivc_pkg.sv
package sivc_pkg;

    localparam int NUM_CH     = 2;
    localparam int SRC_PER_CH = 3;
    localparam int NUM_SRC    = NUM_CH * SRC_PER_CH;
    localparam int SRC_W      = $clog2(NUM_SRC);
    localparam int CODE_W     = 3;
    localparam int LINES_W    = 3;

    // source offset inside one channel (also the rank inside the channel)
    localparam int OFS_RX  = 0;
    localparam int OFS_TX  = 1;
    localparam int OFS_EXT = 2;

    typedef enum logic [1:0] {
        MODE_ASYNC    = 2'b00,
        MODE_BYTESYNC = 2'b01,
        MODE_BITSYNC  = 2'b10,
        MODE_RSVD     = 2'b11
    } ch_mode_e;

    // type field of the vector code
    localparam logic [1:0] TY_TX   = 2'b00;
    localparam logic [1:0] TY_EXT  = 2'b01;
    localparam logic [1:0] TY_RX   = 2'b10;
    localparam logic [1:0] TY_SPEC = 2'b11;

    function automatic logic [CODE_W-1:0] src_code(input logic [SRC_W-1:0] idx,
                                                   input logic special);
        logic [1:0] ty;
        int unsigned ch;
        int unsigned ofs;
        ch  = int'(idx) / SRC_PER_CH;
        ofs = int'(idx) % SRC_PER_CH;
        case (ofs)
            OFS_RX:  ty = special ? TY_SPEC : TY_RX;
            OFS_TX:  ty = TY_TX;
            default: ty = TY_EXT;
        endcase
        return {(ch == 0), ty};
    endfunction

endpackage

// File: rtl/sivc_ext_detect.sv
module sivc_ext_detect
    import sivc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic [LINES_W-1:0] lines,
    input  logic               brk,
    input  logic               abrt,
    input  logic               undr,
    input  logic               rearm,
    output logic               event_o
);

    typedef struct packed {
        logic [LINES_W-1:0] snap;
        logic               latched;
        logic               primed;
    } det_t;

    det_t st_d, st_q;
    logic mode_evt;

    always_comb begin
        st_d     = st_q;
        event_o  = 1'b0;
        mode_evt = (brk  && (mode == MODE_ASYNC)) ||
                   (abrt && (mode == MODE_BITSYNC)) ||
                   (undr && ((mode == MODE_BYTESYNC) || (mode == MODE_BITSYNC)));
        if (rearm) begin
            st_d.latched = 1'b0;
            st_d.snap    = lines;
            st_d.primed  = 1'b1;
        end else if (!st_q.primed) begin
            st_d.snap   = lines;
            st_d.primed = 1'b1;
        end else if (!st_q.latched) begin
            if ((lines != st_q.snap) || mode_evt) begin
                event_o      = 1'b1;
                st_d.latched = 1'b1;
            end
            st_d.snap = lines;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sivc_prio_arb.sv
module sivc_prio_arb
    import sivc_pkg::*;
(
    input  logic [NUM_SRC-1:0] pending,
    input  logic [NUM_SRC-1:0] inserv,
    output logic               win_valid,
    output logic [SRC_W-1:0]   win_idx,
    output logic               svc_valid,
    output logic [SRC_W-1:0]   svc_idx,
    output logic               request
);

    logic [NUM_SRC-1:0] eligible;

    always_comb begin
        eligible  = pending & ~inserv;
        win_valid = 1'b0;
        win_idx   = '0;
        svc_valid = 1'b0;
        svc_idx   = '0;
        // scan from lowest rank up so the top-ranked (lowest index) wins
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                win_valid = 1'b1;
                win_idx   = SRC_W'(i);
            end
            if (inserv[i]) begin
                svc_valid = 1'b1;
                svc_idx   = SRC_W'(i);
            end
        end
        request = win_valid && (!svc_valid || (win_idx < svc_idx));
    end

endmodule

// File: rtl/serial_irq_ctrl.sv
module serial_irq_ctrl
    import sivc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  base_we,
    input  logic [VEC_W-1:0]      base_din,
    input  logic                  ack_rd,
    input  logic                  eoi,
    input  logic [NUM_CH-1:0]     rx_ready,
    input  logic [NUM_CH-1:0]     rx_special,
    input  logic [NUM_CH-1:0]     tx_empty,
    input  logic [2*NUM_CH-1:0]   ch_mode,
    input  logic [NUM_CH-1:0]     dcd,
    input  logic [NUM_CH-1:0]     cts,
    input  logic [NUM_CH-1:0]     sync,
    input  logic [NUM_CH-1:0]     break_det,
    input  logic [NUM_CH-1:0]     abort_det,
    input  logic [NUM_CH-1:0]     tx_underrun,
    input  logic [NUM_CH-1:0]     ext_reset,
    output logic                  int_n,
    output logic [VEC_W-1:0]      vector
);

    localparam int CODE_LSB = 1;
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;
    localparam logic [VEC_W-1:0] CODE_MASK = VEC_W'(((1 << CODE_W) - 1) << CODE_LSB);

    typedef struct packed {
        logic [NUM_SRC-1:0] pending;
        logic [NUM_SRC-1:0] inserv;
        logic [NUM_CH-1:0]  special;
        logic [VEC_W-1:0]   base;
        logic [VEC_W-1:0]   vec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_CH-1:0] ext_evt;
    logic              win_valid;
    logic [SRC_W-1:0]  win_idx;
    logic              svc_valid;
    logic [SRC_W-1:0]  svc_idx;
    logic              request;
    logic              ack_fire;
    logic [CODE_W-1:0] win_code;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ext
        sivc_ext_detect u_ext (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (ch_mode[2*c +: 2]),
            .lines   ({sync[c], cts[c], dcd[c]}),
            .brk     (break_det[c]),
            .abrt    (abort_det[c]),
            .undr    (tx_underrun[c]),
            .rearm   (ext_reset[c]),
            .event_o (ext_evt[c])
        );
    end

    sivc_prio_arb u_arb (
        .pending   (ctl_q.pending),
        .inserv    (ctl_q.inserv),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .svc_valid (svc_valid),
        .svc_idx   (svc_idx),
        .request   (request)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ack_fire = ack_rd && request;
        win_code = src_code(win_idx, ctl_q.special[int'(win_idx) / SRC_PER_CH]);

        // retire the highest cause in service
        if (eoi && svc_valid) begin
            ctl_d.inserv[svc_idx] = 1'b0;
        end

        // acknowledge: winner leaves pending, enters service, vector built
        if (ack_fire) begin
            ctl_d.pending[win_idx] = 1'b0;
            ctl_d.inserv[win_idx]  = 1'b1;
            ctl_d.vec = (ctl_q.base & ~CODE_MASK) |
                        (VEC_W'(win_code) << CODE_LSB);
            if ((int'(win_idx) % SRC_PER_CH) == OFS_RX) begin
                ctl_d.special[int'(win_idx) / SRC_PER_CH] = 1'b0;
            end
        end

        // new causes are set last so a same-cycle event is never lost
        for (int c = 0; c < NUM_CH; c++) begin
            if (rx_ready[c]) begin
                ctl_d.pending[c*SRC_PER_CH + OFS_RX] = 1'b1;
                if (rx_special[c]) begin
                    ctl_d.special[c] = 1'b1;
                end
            end
            if (tx_empty[c]) begin
                ctl_d.pending[c*SRC_PER_CH + OFS_TX] = 1'b1;
            end
            if (ext_evt[c]) begin
                ctl_d.pending[c*SRC_PER_CH + OFS_EXT] = 1'b1;
            end
        end

        if (base_we) begin
            ctl_d.base = base_din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign int_n  = ~request;
    assign vector = ctl_q.vec;

endmodule

module sivc_chk
    import sivc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_rd,
    input logic               eoi,
    input logic               int_n,
    input logic [SRC_W-1:0]   win_idx,
    input logic [NUM_SRC-1:0] pending_q,
    input logic [NUM_SRC-1:0] inserv_q,
    input logic [VEC_W-1:0]   vector
);

    assert_ack_enters_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !int_n) |=> inserv_q[$past(win_idx)]);

    assert_idle_ack_no_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && int_n && !eoi) |=> $stable(inserv_q));

    assert_vector_only_on_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_rd && !int_n) |=> $stable(vector));

    assert_eoi_retires_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !(ack_rd && !int_n) && (inserv_q != '0))
        |=> ($countones(inserv_q) == $countones($past(inserv_q)) - 1));

    assert_request_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> ((pending_q & ~inserv_q) != '0));

endmodule

bind serial_irq_ctrl sivc_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_rd    (ack_rd),
    .eoi       (eoi),
    .int_n     (int_n),
    .win_idx   (win_idx),
    .pending_q (ctl_q.pending),
    .inserv_q  (ctl_q.inserv),
    .vector    (vector)
);

// File: tb/serial_irq_ctrl_tb_top.sv
module serial_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_we = 1'b0;
    logic [7:0] base_din = '0;
    logic       ack_rd = 1'b0;
    logic       eoi = 1'b0;
    logic [1:0] rx_ready = '0, rx_special = '0, tx_empty = '0;
    logic [3:0] ch_mode = '0;
    logic [1:0] dcd = '0, cts = '0, sync = '0;
    logic [1:0] break_det = '0, abort_det = '0, tx_underrun = '0, ext_reset = '0;
    logic       int_n;
    logic [7:0] vector;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    serial_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_din(base_din),
        .ack_rd(ack_rd), .eoi(eoi), .rx_ready(rx_ready), .rx_special(rx_special),
        .tx_empty(tx_empty), .ch_mode(ch_mode), .dcd(dcd), .cts(cts), .sync(sync),
        .break_det(break_det), .abort_det(abort_det), .tx_underrun(tx_underrun),
        .ext_reset(ext_reset), .int_n(int_n), .vector(vector)
    );

    // {raise mask[5:0], expected vector[7:0]}; mask bits: 0 ch0 rx, 1 ch0 tx,
    // 2 ch0 ext (dcd toggle), 3 ch1 rx, 4 ch1 tx, 5 ch1 ext (cts toggle)
    localparam int NV = 9;
    localparam logic [13:0] TBL [NV] = '{
        14'h01AC, 14'h02A8, 14'h04AA, 14'h08A4, 14'h10A0,
        14'h20A2, 14'h36A8, 14'h28A4, 14'h3FAC
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic raise(input logic [5:0] m);
        rx_ready[0] = m[0]; tx_empty[0] = m[1]; if (m[2]) dcd[0] = ~dcd[0];
        rx_ready[1] = m[3]; tx_empty[1] = m[4]; if (m[5]) cts[1] = ~cts[1];
        step();
        rx_ready = '0; tx_empty = '0;
    endtask

    task automatic do_ack();
        ack_rd = 1'b1; step(); ack_rd = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1; step(); eoi = 1'b0;
    endtask

    task automatic rearm(input logic [1:0] m);
        ext_reset = m; step(); ext_reset = '0;
    endtask

    task automatic pulse_evt(input int kind);
        case (kind)
            0: break_det[0] = 1'b1;
            1: abort_det[0] = 1'b1;
            default: tx_underrun[0] = 1'b1;
        endcase
        step();
        break_det = '0; abort_det = '0; tx_underrun = '0;
    endtask

    task automatic drain();
        for (int k = 0; k < 16; k++) begin
            if (!int_n) do_ack(); else do_eoi();
        end
        rearm(2'b11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(); step();
        check("R1 int_n after reset", 32'(int_n), 1);
        check("R1 vector after reset", 32'(vector), 0);
        rst_n = 1'b1;
        step(); step();
        check("R1 int_n idle", 32'(int_n), 1);

        base_we = 1'b1; base_din = 8'hA0; step(); base_we = 1'b0;

        // table walk: R2 priority, R3 codes, R8 line changes
        for (int i = 0; i < NV; i++) begin
            raise(TBL[i][13:8]);
            check("R4 request raised", 32'(int_n), 0);
            do_ack();
            check("R2 R3 R8 table vector", 32'(vector), 32'(TBL[i][7:0]));
            drain();
        end

        // nesting: R4 preemption, R5 hold, R6, R7
        raise(6'h08); do_ack();
        check("R6 vector ch1 rx", 32'(vector), 8'hA4);
        check("R6 int_n high after ack", 32'(int_n), 1);
        raise(6'h02);
        check("R4 higher cause preempts", 32'(int_n), 0);
        do_ack();
        check("R6 vector ch0 tx", 32'(vector), 8'hA8);
        raise(6'h10);
        check("R5 lower cause held", 32'(int_n), 1);
        do_eoi();
        check("R7 eoi retires only top", 32'(int_n), 1);
        do_eoi();
        check("R5 held cause released", 32'(int_n), 0);
        do_ack();
        check("R5 released vector", 32'(vector), 8'hA0);
        do_eoi();
        check("R7 all retired", 32'(int_n), 1);

        // R9 idle acknowledge
        do_ack();
        check("R9 vector unchanged", 32'(vector), 8'hA0);
        check("R9 int_n unchanged", 32'(int_n), 1);
        raise(6'h01); do_ack();
        check("R9 later ack normal", 32'(vector), 8'hAC);
        do_eoi();

        // R12 special receive
        rx_special[1] = 1'b1; raise(6'h08); rx_special = '0;
        do_ack();
        check("R12 special code", 32'(vector), 8'hA6);
        do_eoi();
        raise(6'h08); do_ack();
        check("R12 flag cleared", 32'(vector), 8'hA4);
        do_eoi();

        // R11 latching of external/status
        sync[0] = 1'b1; step();
        check("R8 sync change raises", 32'(int_n), 0);
        do_ack(); do_eoi();
        cts[0] = 1'b1; step(); step();
        check("R11 change ignored while latched", 32'(int_n), 1);
        rearm(2'b01); step();
        check("R11 rearm no spurious", 32'(int_n), 1);
        dcd[0] = ~dcd[0]; step();
        check("R11 after rearm raises", 32'(int_n), 0);
        do_ack();
        check("R11 vector ch0 ext", 32'(vector), 8'hAA);
        do_eoi(); rearm(2'b01);

        // R10 mode qualification on channel 0
        ch_mode[1:0] = 2'b00; pulse_evt(0);
        check("R10 break in async", 32'(int_n), 0);
        drain();
        pulse_evt(1); step();
        check("R10 abort ignored in async", 32'(int_n), 1);
        pulse_evt(2); step();
        check("R10 underrun ignored in async", 32'(int_n), 1);
        ch_mode[1:0] = 2'b01;
        pulse_evt(0); step();
        check("R10 break ignored in byte-sync", 32'(int_n), 1);
        pulse_evt(2);
        check("R10 underrun in byte-sync", 32'(int_n), 0);
        drain();
        ch_mode[1:0] = 2'b10;
        pulse_evt(1);
        check("R10 abort in bit-sync", 32'(int_n), 0);
        drain();
        ch_mode[1:0] = 2'b11;
        pulse_evt(0); pulse_evt(1); pulse_evt(2); step();
        check("R10 reserved mode ignores events", 32'(int_n), 1);
        ch_mode[1:0] = 2'b00;

        // R3 base bits pass through
        base_we = 1'b1; base_din = 8'h5F; step(); base_we = 1'b0;
        raise(6'h01); do_ack();
        check("R3 base merge ch0 rx", 32'(vector), 8'h5D);
        do_eoi();
        raise(6'h10); do_ack();
        check("R3 base merge ch1 tx", 32'(vector), 8'h51);
        do_eoi();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule